// File: doc/BRIEF.md
# Ping-Pong Burst-to-Stream Audio Buffer

This block sits between a source that delivers audio in bursts, one complete block every few milliseconds, and a serializer that needs one multichannel frame every sample period. A block holds a fixed number of frames, and every frame carries one sample for each channel. With the defaults (48 kHz, 4 ms, eight channels) that is 192 frames and 1,536 samples per block. Two storage banks take turns. One bank collects the incoming burst while the other is drained one frame per serializer request. The roles swap only when the collecting bank holds a whole block and the draining bank is empty.

The producer presents one sample at a time with its channel index. Within a frame, channels may arrive in any order, and gaps between samples are allowed. The frame closes when the highest-numbered channel is written. The serializer pulses `rd_req` once per sample period. One cycle later it receives `rd_ack` together with all channels of one frame packed into a single word.

Control is a three-state machine:
- **PRIMING**: after reset, no block has been handed over yet.
- **STREAMING**: the read bank still holds frames.
- **STARVED**: the read bank has been drained and no complete block is waiting.

Its transitions are:
- **first-handover**: PRIMING to STREAMING.
- **drain-out**: STREAMING to STARVED, taken when the last frame is served.
- **refill**: STARVED to STREAMING.

The first-handover and refill transitions both happen through a bank swap. Two sticky flags report two conditions: data lost because both banks were occupied, and frames that were requested but could not be supplied.

Top module: `pingpong_audio_buf`

## Requirements
- R1: While reset is active and after its release, `rd_ack`, `rd_data`, `overflow` and `underrun` are all zero.
- R2: An accepted write stores `wr_sample` as channel `wr_chan` of the current frame of the write bank. The frame index starts at 0 and advances only after a write to channel CHANNELS-1. The bank becomes complete after that write in frame FRAMES-1.
- R3: `rd_ack` is high exactly one cycle after each `rd_req` cycle. `rd_data` carries channel c in bits [c*DATA_W +: DATA_W] and holds its value between acknowledgements.
- R4: A handed-over block is read out in frame order 0 to FRAMES-1, one frame per request, with each sample as written.
- R5: The banks swap in the first cycle in which the write bank is complete and the read bank is drained. A request in that same cycle is served frame 0 of the new block. A write in that same cycle is accepted into frame 0 of the freed bank.
- R6: Until the first swap, every request is acknowledged with all-zero data and does not set `underrun`.
- R7: After the first swap, a request that meets a drained read bank with no swap possible is acknowledged with all-zero data, and `underrun` is high from the next cycle.
- R8: A write presented while the write bank is complete and the read bank still holds frames is dropped, leaving all stored frames unchanged, and `overflow` is high from the next cycle.
- R9: Once set, `overflow` and `underrun` stay high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A sample is presented on the write port |
| wr_chan | input | $clog2(CHANNELS) | Channel index of the presented sample |
| wr_sample | input | DATA_W | Sample value |
| rd_req | input | 1 | Serializer asks for the next frame |
| rd_ack | output | 1 | Frame answer valid, one cycle after a request |
| rd_data | output | CHANNELS*DATA_W | Packed frame, channel c at bits [c*DATA_W +: DATA_W] |
| overflow | output | 1 | Sticky: a write was dropped |
| underrun | output | 1 | Sticky: a request found no frame |

## Verification
The bench builds the block with CHANNELS=4, FRAMES=6 and DATA_W=16. A whole block is therefore 24 writes, and a drain is six requests. This puts dozens of swaps, repeated drain-out and refill transitions, overflow from back-to-back bursts, and underrun from fast request streams within a few thousand cycles. The same-cycle swap, where a write and a request meet a handover, is driven directly and also recurs under the random traffic.

// File: rtl/pab_pkg.sv
package pab_pkg;
    typedef enum logic [1:0] {
        ST_PRIMING   = 2'd0,
        ST_STREAMING = 2'd1,
        ST_STARVED   = 2'd2
    } stream_state_t;
endpackage

// File: rtl/pab_bank_ram.sv
module pab_bank_ram #(
    parameter int WIDTH = 24,
    parameter int DEPTH = 192,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/pab_wr_ctrl.sv
module pab_wr_ctrl #(
    parameter int CHANNELS = 8,
    parameter int FRAMES   = 192,
    localparam int CH_W    = $clog2(CHANNELS),
    localparam int FR_W    = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_valid,
    input  logic [CH_W-1:0] wr_chan,
    input  logic            swap,
    output logic            accept,
    output logic            drop,
    output logic [FR_W-1:0] frame_idx,
    output logic            full
);
    logic [FR_W-1:0] frame_q;
    logic            full_q;
    logic            eff_full;

    always_comb begin
        eff_full  = full_q && !swap;
        frame_idx = swap ? '0 : frame_q;
        accept    = wr_valid && !eff_full;
        drop      = wr_valid && eff_full;
        full      = full_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
            full_q  <= 1'b0;
        end else begin
            frame_q <= frame_idx;
            full_q  <= eff_full;
            if (accept && wr_chan == CH_W'(CHANNELS - 1)) begin
                if (frame_idx == FR_W'(FRAMES - 1)) begin
                    frame_q <= '0;
                    full_q  <= 1'b1;
                end else begin
                    frame_q <= frame_idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pab_rd_ctrl.sv
module pab_rd_ctrl
    import pab_pkg::*;
#(
    parameter int FRAMES = 192,
    localparam int FR_W  = (FRAMES > 1) ? $clog2(FRAMES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_req,
    input  logic            wr_full,
    output logic            swap,
    output logic            serve,
    output logic            starve,
    output logic [FR_W-1:0] frame_idx,
    output stream_state_t   state
);
    stream_state_t   state_q, state_d;
    logic [FR_W-1:0] ptr_q;
    logic            last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PRIMING;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= serve ? (last ? '0 : frame_idx + 1'b1) : frame_idx;
        end
    end

    // outputs and next state
    always_comb begin
        swap      = wr_full && (state_q != ST_STREAMING);
        frame_idx = swap ? '0 : ptr_q;
        serve     = rd_req && (swap || state_q == ST_STREAMING);
        starve    = rd_req && !serve && (state_q == ST_STARVED);
        last      = serve && (frame_idx == FR_W'(FRAMES - 1));
        state     = state_q;
        state_d   = state_q;
        unique case (state_q)
            ST_PRIMING:   if (swap) state_d = last ? ST_STARVED : ST_STREAMING;
            ST_STREAMING: if (last) state_d = ST_STARVED;
            ST_STARVED:   if (swap) state_d = last ? ST_STARVED : ST_STREAMING;
            default:      state_d = ST_PRIMING;
        endcase
    end
endmodule

// File: rtl/pingpong_audio_buf.sv
module pingpong_audio_buf
    import pab_pkg::*;
#(
    parameter int CHANNELS = 8,
    parameter int FRAMES   = 192,
    parameter int DATA_W   = 24,
    localparam int CH_W    = $clog2(CHANNELS),
    localparam int FR_W    = (FRAMES > 1) ? $clog2(FRAMES) : 1,
    localparam int OUT_W   = CHANNELS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [CH_W-1:0]   wr_chan,
    input  logic [DATA_W-1:0] wr_sample,
    input  logic              rd_req,
    output logic              rd_ack,
    output logic [OUT_W-1:0]  rd_data,
    output logic              overflow,
    output logic              underrun
);
    logic            swap, serve, starve, accept, drop, wr_full;
    logic [FR_W-1:0] wr_frame, rd_frame;
    stream_state_t   state;
    logic            sel_q, wsel, rsel_q, zero_q, ack_q, ovf_q, udr_q;
    logic [DATA_W-1:0] ram_q [2][CHANNELS];

    pab_wr_ctrl #(.CHANNELS(CHANNELS), .FRAMES(FRAMES)) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .swap(swap), .accept(accept), .drop(drop), .frame_idx(wr_frame),
        .full(wr_full)
    );

    pab_rd_ctrl #(.FRAMES(FRAMES)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_full(wr_full),
        .swap(swap), .serve(serve), .starve(starve), .frame_idx(rd_frame),
        .state(state)
    );

    // bank that takes writes this cycle; the other one is read
    assign wsel = sel_q ^ swap;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
            pab_bank_ram #(.WIDTH(DATA_W), .DEPTH(FRAMES)) u_ram (
                .clk(clk),
                .we(accept && (wsel == (b != 0)) && (wr_chan == CH_W'(c))),
                .waddr(wr_frame),
                .wdata(wr_sample),
                .re(serve && (wsel != (b != 0))),
                .raddr(rd_frame),
                .rdata(ram_q[b][c])
            );
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            rsel_q <= 1'b0;
            zero_q <= 1'b1;
            ack_q  <= 1'b0;
            ovf_q  <= 1'b0;
            udr_q  <= 1'b0;
        end else begin
            sel_q <= wsel;
            ack_q <= rd_req;
            if (rd_req) zero_q <= !serve;
            if (serve)  rsel_q <= !wsel;
            if (drop)   ovf_q  <= 1'b1;
            if (starve) udr_q  <= 1'b1;
        end
    end

    always_comb begin
        for (int c = 0; c < CHANNELS; c++) begin
            rd_data[c*DATA_W +: DATA_W] = zero_q ? '0 : ram_q[rsel_q][c];
        end
        rd_ack   = ack_q;
        overflow = ovf_q;
        underrun = udr_q;
    end
endmodule

// File: rtl/pab_chk.sv
module pab_chk
    import pab_pkg::*;
#(
    parameter int CHANNELS = 8,
    parameter int DATA_W   = 24
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_valid,
    input logic                       rd_req,
    input logic                       rd_ack,
    input logic [CHANNELS*DATA_W-1:0] rd_data,
    input logic                       overflow,
    input logic                       underrun,
    input stream_state_t              state
);
    assert_ack_follows_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_ack);
    assert_no_spurious_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_ack);
    assert_priming_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && state == ST_PRIMING) |-> (rd_data == '0 && !underrun));
    assert_underrun_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underrun) |-> (rd_ack && rd_data == '0));
    assert_overflow_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(wr_valid));
    assert_overflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);
endmodule

bind pingpong_audio_buf pab_chk #(.CHANNELS(CHANNELS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_req(rd_req),
    .rd_ack(rd_ack), .rd_data(rd_data), .overflow(overflow),
    .underrun(underrun), .state(state)
);

// File: tb/sim_pingpong_audio_buf.sv
module sim_pingpong_audio_buf;
    localparam int CH = 4;
    localparam int F  = 6;
    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0;
    logic [1:0] wr_chan = '0;
    logic [DW-1:0] wr_sample = '0;
    logic rd_req = 1'b0;
    logic rd_ack, overflow, underrun;
    logic [CH*DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "R1";

    // reference model
    logic [DW-1:0] wb [F][CH];
    logic [DW-1:0] rb [F][CH];
    logic [DW-1:0] e_data [CH];
    int  m_wframe = 0, m_rcount = 0, m_rpos = 0;
    bit  m_wfull = 0, m_primed = 0;
    bit  e_ack = 0, e_ovf = 0, e_udr = 0;
    int  chan_ctr = 0;

    pingpong_audio_buf #(.CHANNELS(CH), .FRAMES(F), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
        .wr_sample(wr_sample), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_data(rd_data), .overflow(overflow), .underrun(underrun)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model(input bit wv, input int ch, input logic [DW-1:0] d, input bit rq);
        if (m_wfull && m_rcount == 0) begin
            for (int f = 0; f < F; f++)
                for (int c = 0; c < CH; c++) begin
                    logic [DW-1:0] t;
                    t = rb[f][c]; rb[f][c] = wb[f][c]; wb[f][c] = t;
                end
            m_rcount = F; m_rpos = 0; m_wfull = 0; m_wframe = 0; m_primed = 1;
        end
        if (wv) begin
            if (m_wfull) e_ovf = 1;
            else begin
                wb[m_wframe][ch] = d;
                if (ch == CH - 1) begin
                    if (m_wframe == F - 1) begin m_wfull = 1; m_wframe = 0; end
                    else m_wframe++;
                end
            end
        end
        e_ack = rq;
        if (rq) begin
            if (m_rcount > 0) begin
                for (int c = 0; c < CH; c++) e_data[c] = rb[m_rpos][c];
                m_rpos++; m_rcount--;
            end else begin
                for (int c = 0; c < CH; c++) e_data[c] = '0;
                if (m_primed) e_udr = 1;
            end
        end
    endtask

    task automatic compare();
        chk(rd_ack == e_ack, "R3", "rd_ack", rd_ack, e_ack);
        for (int c = 0; c < CH; c++)
            chk(rd_data[c*DW +: DW] == e_data[c], tag, $sformatf("rd_data ch%0d", c),
                rd_data[c*DW +: DW], e_data[c]);
        chk(overflow == e_ovf, (tag == "R9") ? "R9" : "R8", "overflow", overflow, e_ovf);
        chk(underrun == e_udr, (tag == "R9") ? "R9" : "R7", "underrun", underrun, e_udr);
    endtask

    // called at a falling edge: drive, predict, advance one cycle, compare
    task automatic step(input bit wv, input int ch, input logic [DW-1:0] d, input bit rq);
        wr_valid = wv; wr_chan = 2'(ch); wr_sample = d; rd_req = rq;
        model(wv, ch, d, rq);
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic write_block(input int gap);
        for (int f = 0; f < F; f++)
            for (int c = 0; c < CH; c++) begin
                step(1, c, DW'($urandom), 0);
                for (int g = 0; g < gap; g++) step(0, 0, '0, 0);
            end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int c = 0; c < CH; c++) e_data[c] = '0;
        repeat (3) @(negedge clk);
        compare();                                   // R1 during reset
        rst_n = 1'b1;
        step(0, 0, '0, 0);                            // R1 after release

        tag = "R6";
        repeat (3) step(0, 0, '0, 1);                 // requests before any block

        tag = "R2";
        write_block(1);                               // first block with gaps
        tag = "R4";
        for (int i = 0; i < F; i++) step(0, 0, '0, 1);   // R4 drain in order

        tag = "R8";
        write_block(0);                               // fills new write bank
        write_block(0);                               // swap, then fill again
        step(1, 0, 16'hDEAD, 0);                      // dropped: R8
        step(1, 1, 16'hBEEF, 0);
        tag = "R4";
        for (int i = 0; i < F - 1; i++) step(0, 0, '0, 1);

        tag = "R5";
        step(0, 0, '0, 1);                            // last frame -> drained
        step(1, 0, 16'h1234, 1);                      // swap with write+read
        for (int c = 1; c < CH; c++) step(1, c, DW'($urandom), 0);

        tag = "R7";
        for (int i = 0; i < F + 2; i++) step(0, 0, '0, 1);  // drain then underrun

        tag = "R9";
        chan_ctr = 1;
        for (int i = 0; i < 4000; i++) begin
            bit wv, rq;
            wv = ($urandom % 3) != 0;
            rq = ($urandom % 4) == 0;
            step(wv, chan_ctr, DW'($urandom), rq);
            if (wv) chan_ctr = (chan_ctr + 1) % CH;
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule